// File: doc/BRIEF.md
# Power bus message decoder

The decoder takes 16-bit messages from a power-management bus and keeps a 4-bit state register for each power resource it controls. Each resource has a fixed identity in a parameter table: an 8-bit ID, a resource group (power provider, reset/control or peripheral), a type index, a 2-bit secondary type and a device-group membership mask. A message either names one resource by ID (singular) or selects every resource that matches a group mask, a type mask and a secondary type (broadcast).

A message carries a device-group field. It takes effect only on resources that belong to one of the addressed device groups. A zero device-group field is the null group and reaches every resource. The state field is written into each selected resource one clock after the message is presented. A message that carries an undefined state code leaves every resource untouched and raises an error flag for one cycle.

Top module: `pwrbus_decoder`

## Requirements
- R1: During and after reset, every resource state is 0x0 (off) and `bad_state` is low until a message arrives.
- R2: With bit 12 = 0 (singular), bits 11:4 give a resource ID. The resource with that ID, and no other, takes the state in bits 3:0 on the clock edge that accepts the message, so the new value is visible one cycle after `msg_valid`.
- R3: Bits 15:13 are a device-group mask (0x1 group 1, 0x2 group 2, 0x4 group 3). A non-zero mask affects a resource only if the mask shares a bit with the resource's membership. Other resources keep their state.
- R4: A device-group field of 0 (null group) makes the message apply regardless of membership.
- R5: With bit 12 = 1 (broadcast), a resource is updated only when all three conditions hold. Its group bit must be set in bits 11:9 (bit 9 power provider, bit 10 reset/control, bit 11 peripheral). Its type-index bit must be set in bits 6:4 (bit 4 type 0, bit 5 type 1, bit 6 type 2). Its secondary type must equal bits 8:7.
- R6: Only state codes 0xF (warm reset), 0xE (active), 0x8 (sleep) and 0x0 (off) are applied. Any other code changes no resource, and `bad_state` is high for exactly the one cycle after that message.
- R7: While `msg_valid` is low, no state changes and `bad_state` is low.
- R8: A singular message whose ID matches no resource in the table changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message present on `msg_data` this cycle |
| msg_data | input | 16 | Power-bus message |
| res_state | output | NUM_RES*4 | Resource states, resource i at bits 4i+3:4i |
| bad_state | output | 1 | One-cycle pulse after a message with an undefined state code |

## Verification
The bench addresses a resource through a device group it does not belong to and expects no change; a design that ignores membership would write it anyway. Broadcasts are sent that differ from a resource in only one field: group, type or secondary type. A decoder that drops any one of the three tests would update resources that should keep their state. Undefined state codes are sent back to back with a legal message. This catches a decoder that writes the bad code, that holds the error flag high, or that loses the following message. An unknown ID and an idle bus carrying a full message pattern must both leave every state as it was.

// File: rtl/pwrbus_pkg.sv
package pwrbus_pkg;

    localparam int STATE_W = 4;
    localparam int ID_W    = 8;
    localparam int DEVG_W  = 3;
    localparam int MASK_W  = 3;
    localparam int T2_W    = 2;
    localparam int MSG_W   = DEVG_W + 1 + MASK_W + T2_W + MASK_W + STATE_W;

    typedef logic [STATE_W-1:0] pstate_t;

    localparam pstate_t ST_OFF    = 4'h0;
    localparam pstate_t ST_SLEEP  = 4'h8;
    localparam pstate_t ST_ACTIVE = 4'hE;
    localparam pstate_t ST_WRST   = 4'hF;

    // Decoded view of one message; id overlaps the broadcast mask fields.
    typedef struct packed {
        logic [DEVG_W-1:0] devg;
        logic              bcast;
        logic [ID_W-1:0]   id;
        logic [MASK_W-1:0] grp_mask;
        logic [T2_W-1:0]   type2;
        logic [MASK_W-1:0] type_mask;
        pstate_t           state;
    } pmsg_t;

    function automatic logic state_is_legal(input pstate_t s);
        logic ok;
        case (s)
            ST_OFF, ST_SLEEP, ST_ACTIVE, ST_WRST: ok = 1'b1;
            default:                              ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pwrbus_field_split.sv
module pwrbus_field_split
    import pwrbus_pkg::*;
(
    input  logic [MSG_W-1:0] raw,
    output pmsg_t            fields,
    output logic             legal
);

    always_comb begin
        fields.devg      = raw[15:13];
        fields.bcast     = raw[12];
        fields.id        = raw[11:4];
        fields.grp_mask  = raw[11:9];
        fields.type2     = raw[8:7];
        fields.type_mask = raw[6:4];
        fields.state     = raw[3:0];
        legal            = state_is_legal(raw[3:0]);
    end

endmodule

// File: rtl/pwrbus_res_match.sv
module pwrbus_res_match
    import pwrbus_pkg::*;
#(
    parameter logic [ID_W-1:0]   RES_ID   = 8'h00,
    parameter logic [1:0]        RES_GRP  = 2'd0,
    parameter logic [1:0]        RES_TYPE = 2'd0,
    parameter logic [T2_W-1:0]   RES_T2   = 2'd0,
    parameter logic [DEVG_W-1:0] RES_DEVM = 3'b001
) (
    input  pmsg_t fields,
    output logic  hit
);

    localparam logic [MASK_W-1:0] GRP_BIT  = MASK_W'(1) << RES_GRP;
    localparam logic [MASK_W-1:0] TYPE_BIT = MASK_W'(1) << RES_TYPE;

    logic dev_ok;
    logic sel_ok;

    always_comb begin
        dev_ok = (fields.devg == '0) || (|(fields.devg & RES_DEVM));
        if (fields.bcast) begin
            sel_ok = (|(fields.grp_mask & GRP_BIT))
                  && (|(fields.type_mask & TYPE_BIT))
                  && (fields.type2 == RES_T2);
        end else begin
            sel_ok = (fields.id == RES_ID);
        end
        hit = dev_ok && sel_ok;
    end

endmodule

// File: rtl/pwrbus_decoder.sv
module pwrbus_decoder
    import pwrbus_pkg::*;
#(
    parameter int NUM_RES = 8,
    parameter logic [NUM_RES*ID_W-1:0]   RES_ID   =
        {8'h1B, 8'h19, 8'h17, 8'h10, 8'h0F, 8'h07, 8'h06, 8'h05},
    parameter logic [NUM_RES*2-1:0]      RES_GRP  =
        {2'd1, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0},
    parameter logic [NUM_RES*2-1:0]      RES_TYPE =
        {2'd2, 2'd2, 2'd0, 2'd2, 2'd1, 2'd0, 2'd1, 2'd0},
    parameter logic [NUM_RES*T2_W-1:0]   RES_T2   =
        {2'd2, 2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0},
    parameter logic [NUM_RES*DEVG_W-1:0] RES_DEVM =
        {3'b010, 3'b111, 3'b100, 3'b011, 3'b100, 3'b001, 3'b010, 3'b001}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    input  logic [MSG_W-1:0]           msg_data,
    output logic [NUM_RES*STATE_W-1:0] res_state,
    output logic                       bad_state
);

    typedef struct packed {
        logic [NUM_RES-1:0][STATE_W-1:0] st;
        logic                            bad;
    } dec_reg_t;

    dec_reg_t          reg_d;
    dec_reg_t          reg_q;
    pmsg_t             fields;
    logic              legal;
    logic [NUM_RES-1:0] hit;

    pwrbus_field_split u_split (
        .raw    (msg_data),
        .fields (fields),
        .legal  (legal)
    );

    for (genvar gi = 0; gi < NUM_RES; gi++) begin : g_res
        pwrbus_res_match #(
            .RES_ID   (RES_ID  [gi*ID_W   +: ID_W]),
            .RES_GRP  (RES_GRP [gi*2      +: 2]),
            .RES_TYPE (RES_TYPE[gi*2      +: 2]),
            .RES_T2   (RES_T2  [gi*T2_W   +: T2_W]),
            .RES_DEVM (RES_DEVM[gi*DEVG_W +: DEVG_W])
        ) u_match (
            .fields (fields),
            .hit    (hit[gi])
        );
    end

    always_comb begin
        reg_d     = reg_q;
        reg_d.bad = 1'b0;
        if (msg_valid) begin
            if (!legal) begin
                reg_d.bad = 1'b1;
            end else begin
                for (int i = 0; i < NUM_RES; i++) begin
                    if (hit[i]) begin
                        reg_d.st[i] = fields.state;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.st  <= '{default: ST_OFF};
            reg_q.bad <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign res_state = reg_q.st;
    assign bad_state = reg_q.bad;

endmodule

// File: rtl/pwrbus_decoder_chk.sv
module pwrbus_decoder_chk
    import pwrbus_pkg::*;
#(
    parameter int NUM_RES = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       msg_valid,
    input logic [MSG_W-1:0]           msg_data,
    input logic [NUM_RES*STATE_W-1:0] res_state,
    input logic                       bad_state
);

    // R7: an idle bus leaves every state alone.
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(msg_valid) |-> $stable(res_state));

    // R7: the error flag never rises without a message.
    assert_bad_needs_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(msg_valid) |-> !bad_state);

    // R6: a rejected message changes nothing.
    assert_bad_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_state |-> $stable(res_state));

    // R6: the error flag reflects the state code of the message before it.
    assert_bad_tracks_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msg_valid) |-> (bad_state == !state_is_legal($past(msg_data[3:0]))));

    for (genvar gi = 0; gi < NUM_RES; gi++) begin : g_chk
        // R6: stored states are always one of the defined codes.
        assert_legal_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
            state_is_legal(res_state[gi*STATE_W +: STATE_W]));
    end

endmodule

bind pwrbus_decoder pwrbus_decoder_chk #(.NUM_RES(NUM_RES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .res_state (res_state),
    .bad_state (bad_state)
);

// File: tb/pwrbus_decoder_tb.sv
module pwrbus_decoder_tb_top;

    localparam int N = 8;

    // Resource table as specified (index 0..7).
    localparam logic [7:0] T_ID   [N] = '{8'h05, 8'h06, 8'h07, 8'h0F, 8'h10, 8'h17, 8'h19, 8'h1B};
    localparam logic [1:0] T_GRP  [N] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1};
    localparam logic [1:0] T_TYP  [N] = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd2};
    localparam logic [1:0] T_T2   [N] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd2};
    localparam logic [2:0] T_DEV  [N] = '{3'b001, 3'b010, 3'b001, 3'b100, 3'b011, 3'b100, 3'b111, 3'b010};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [15:0] msg_data = '0;
    logic [N*4-1:0] res_state;
    logic        bad_state;

    logic [3:0] exp_st [N];
    logic       exp_bad;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwrbus_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .res_state (res_state),
        .bad_state (bad_state)
    );

    function automatic logic [15:0] sing(logic [2:0] dev, logic [7:0] id, logic [3:0] st);
        return {dev, 1'b0, id, st};
    endfunction

    function automatic logic [15:0] bc(logic [2:0] dev, logic [2:0] grp, logic [1:0] t2,
                                       logic [2:0] typ, logic [3:0] st);
        return {dev, 1'b1, grp, t2, typ, st};
    endfunction

    // Expected effect of one accepted message, from the requirements.
    task automatic model(logic [15:0] m);
        logic ok;
        ok = (m[3:0] == 4'h0) || (m[3:0] == 4'h8) || (m[3:0] == 4'hE) || (m[3:0] == 4'hF);
        exp_bad = !ok;
        if (ok) begin
            for (int i = 0; i < N; i++) begin
                logic dv, sl;
                dv = (m[15:13] == 3'b000) || ((m[15:13] & T_DEV[i]) != 3'b000);
                if (m[12])
                    sl = m[9 + T_GRP[i]] && m[4 + T_TYP[i]] && (m[8:7] == T_T2[i]);
                else
                    sl = (m[11:4] == T_ID[i]);
                if (dv && sl) exp_st[i] = m[3:0];
            end
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < N; i++)
            chk(req, 32'(res_state[i*4 +: 4]), 32'(exp_st[i]));
        chk(req, 32'(bad_state), 32'(exp_bad));
    endtask

    // Called at a negedge; returns at the next negedge with results visible.
    task automatic drive(logic [15:0] m);
        msg_valid = 1'b1;
        msg_data  = m;
        model(m);
        @(negedge clk);
    endtask

    task automatic idle(logic [15:0] pattern);
        msg_valid = 1'b0;
        msg_data  = pattern;
        exp_bad   = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_singular();
        drive(sing(3'b001, 8'h05, 4'hE)); check_all("R2");
        drive(sing(3'b000, 8'h1B, 4'h8)); check_all("R2");
        idle(16'h0); check_all("R2");
    endtask

    task automatic t_devgroup();
        drive(sing(3'b010, 8'h05, 4'h8)); check_all("R3");
        drive(sing(3'b100, 8'h0F, 4'h8)); check_all("R3");
        drive(sing(3'b110, 8'h10, 4'hE)); check_all("R3");
        idle(16'h0); check_all("R3");
    endtask

    task automatic t_null();
        drive(sing(3'b000, 8'h17, 4'hF)); check_all("R4");
        drive(bc(3'b000, 3'b111, 2'd0, 3'b111, 4'hE)); check_all("R4");
        idle(16'h0); check_all("R4");
    endtask

    task automatic t_bcast();
        drive(bc(3'b000, 3'b001, 2'd0, 3'b111, 4'h8)); check_all("R5");
        drive(bc(3'b000, 3'b111, 2'd1, 3'b010, 4'h0)); check_all("R5");
        drive(bc(3'b000, 3'b111, 2'd2, 3'b111, 4'hF)); check_all("R5");
        drive(bc(3'b010, 3'b111, 2'd0, 3'b111, 4'h0)); check_all("R5");
        drive(bc(3'b000, 3'b100, 2'd0, 3'b011, 4'hE)); check_all("R5");
        idle(16'h0); check_all("R5");
    endtask

    task automatic t_illegal();
        drive(sing(3'b000, 8'h05, 4'h9)); check_all("R6");
        idle(16'h0); check_all("R6");
        drive(bc(3'b000, 3'b111, 2'd0, 3'b111, 4'h7)); check_all("R6");
        drive(sing(3'b000, 8'h06, 4'hF)); check_all("R6");
        idle(16'h0); check_all("R6");
    endtask

    task automatic t_idle();
        idle(bc(3'b000, 3'b111, 2'd0, 3'b111, 4'h8)); check_all("R7");
        idle(sing(3'b000, 8'h05, 4'h3)); check_all("R7");
    endtask

    task automatic t_unknown();
        drive(sing(3'b000, 8'h33, 4'hE)); check_all("R8");
        idle(16'h0); check_all("R8");
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_st[i] = 4'h0;
        exp_bad = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_singular();
        t_devgroup();
        t_null();
        t_bcast();
        t_illegal();
        t_idle();
        t_unknown();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule